// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block holds recently used virtual-page to physical-frame mappings. Every entry can hold any translation. A lookup presents a virtual address and an access kind. The page number is compared against every stored tag at the same time, and the matching entry's frame number is steered out through an AND-OR multiplexer. If the entry's permission bits allow the access, the frame number is joined to the untouched page offset to form the physical address. A lookup that matches no valid entry is reported as a miss. A lookup that matches an entry but is not permitted is reported as a fault. In both of those cases the address output is zero.

Each entry keeps a reference flag and a modified flag. The reference flag is set when a lookup hits the entry. A one-cycle clear command wipes every reference flag, which lets software approximate least-recently-used tracking. The modified flag is set when a store hits the entry. The block always offers a suggested replacement slot, together with that slot's modified flag, so that a page-table walker can decide whether the evicted page needs a write-back before it installs a new mapping through the fill port.

Top module: `xlat_cache`

## Requirements
- R1: The lookup result is registered. One cycle after `lk_valid_i` is high, exactly one of `lk_hit_o`, `lk_miss_o` and `lk_fault_o` is high. One cycle after `lk_valid_i` is low, all three are low.
- R2: A hit occurs when a valid entry's tag equals `lk_vaddr_i[31:12]` and its permission allows the access. On a hit, `lk_paddr_o` equals the entry's frame number in bits 31:12 and `lk_vaddr_i[11:0]` in bits 11:0.
- R3: When no valid entry matches, which includes every lookup after reset, the block reports a miss and `lk_paddr_o` is zero.
- R4: The permission field uses bit 0 for load, bit 1 for store and bit 2 for fetch. The access code `lk_acc_i` is 00 for load, 01 for store, 10 for fetch, and 11 is treated as a load. If the required permission bit is clear, the block reports a fault and `lk_paddr_o` is zero.
- R5: A hit sets the entry's reference flag. `clr_use_i` clears every reference flag. If a hit and a clear happen in the same cycle, the hit entry's reference flag stays set.
- R6: A store hit sets the entry's modified flag. The flag stays set until the entry is refilled. It is reported on `victim_dirty_o` whenever the entry is the suggested victim.
- R7: `victim_o` names the lowest-indexed invalid entry. If every entry is valid, it names the lowest-indexed entry whose reference flag is clear. If every reference flag is set, it names entry 0.
- R8: A fill writes the entry as valid, with the given tag, frame and permission, and with its reference and modified flags clear. If a valid entry already holds the same tag, that entry is overwritten. Otherwise the fill goes to the entry named by `victim_o`.
- R9: A lookup in the same cycle as a fill sees the contents from before the fill. If both touch the same entry, the fill's values win.
- R10: A faulting lookup changes neither the reference flag nor the modified flag of the entry it matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset; invalidates all entries |
| lk_valid_i | input | 1 | Lookup request |
| lk_vaddr_i | input | 32 | Virtual address to translate |
| lk_acc_i | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 load |
| lk_hit_o | output | 1 | Registered hit result |
| lk_miss_o | output | 1 | Registered miss result |
| lk_fault_o | output | 1 | Registered permission fault |
| lk_paddr_o | output | 32 | Physical address on a hit, otherwise zero |
| fill_valid_i | input | 1 | Install a translation |
| fill_vpn_i | input | 20 | Virtual page number to install |
| fill_pfn_i | input | 20 | Physical frame number to install |
| fill_perm_i | input | 3 | Permission bits {fetch, store, load} |
| clr_use_i | input | 1 | Clear all reference flags |
| victim_o | output | 4 | Suggested replacement entry |
| victim_dirty_o | output | 1 | Modified flag of the suggested entry |

## Verification
The hardest states to reach are those in which every entry is valid and the reference flags form a chosen pattern. Only in those states does the victim pointer show the effect of a clear and a hit arriving in the same cycle, or of a faulting access that must leave the flags alone. The stimulus fills all sixteen entries and clears the flags. It then sets reference flags one at a time with hits, so that the victim pointer moves to a predicted index. This turns each reference flag and modified flag into something the ports can see. A fill timed for the cycle in which the victim is the entry being looked up covers the case of a fill and a lookup colliding on one entry.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_ALT   = 2'b11
    } acc_e;

    localparam int PERM_W   = 3;
    localparam int PERM_LD  = 0;
    localparam int PERM_ST  = 1;
    localparam int PERM_EX  = 2;

    function automatic logic perm_ok(input logic [PERM_W-1:0] perm, input acc_e acc);
        logic ok;
        case (acc)
            ACC_STORE: ok = perm[PERM_ST];
            ACC_FETCH: ok = perm[PERM_EX];
            default:   ok = perm[PERM_LD];
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/xlat_match.sv
module xlat_match
    import xlat_pkg::*;
#(
    parameter int N     = 16,
    parameter int VPN_W = 20,
    parameter int PFN_W = 20
) (
    input  logic [VPN_W-1:0]           vpn_i,
    input  logic [N-1:0]               vld_i,
    input  logic [N-1:0][VPN_W-1:0]    tag_i,
    input  logic [N-1:0][PFN_W-1:0]    pfn_i,
    input  logic [N-1:0][PERM_W-1:0]   perm_i,
    output logic [N-1:0]               hit_vec_o,
    output logic                       any_o,
    output logic [PFN_W-1:0]           pfn_o,
    output logic [PERM_W-1:0]          perm_o
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec_o[g] = vld_i[g] && (tag_i[g] == vpn_i);
    end

    assign any_o = |hit_vec_o;

    always_comb begin
        pfn_o  = '0;
        perm_o = '0;
        for (int i = 0; i < N; i++) begin
            pfn_o  = pfn_o  | (pfn_i[i]  & {PFN_W{hit_vec_o[i]}});
            perm_o = perm_o | (perm_i[i] & {PERM_W{hit_vec_o[i]}});
        end
    end

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int N     = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     vld_i,
    input  logic [N-1:0]     used_i,
    output logic [IDX_W-1:0] idx_o
);

    logic have_free;

    always_comb begin
        idx_o     = '0;
        have_free = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld_i[i]) begin
                idx_o     = IDX_W'(i);
                have_free = 1'b1;
            end
        end
        if (!have_free) begin
            for (int i = N - 1; i >= 0; i--) begin
                if (!used_i[i]) begin
                    idx_o = IDX_W'(i);
                end
            end
        end
    end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int N     = 16,
    parameter int VA_W  = 32,
    parameter int OFS_W = 12,
    parameter int PFN_W = 20,
    localparam int VPN_W = VA_W - OFS_W,
    localparam int PA_W  = PFN_W + OFS_W,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              lk_valid_i,
    input  logic [VA_W-1:0]   lk_vaddr_i,
    input  logic [1:0]        lk_acc_i,
    output logic              lk_hit_o,
    output logic              lk_miss_o,
    output logic              lk_fault_o,
    output logic [PA_W-1:0]   lk_paddr_o,
    input  logic              fill_valid_i,
    input  logic [VPN_W-1:0]  fill_vpn_i,
    input  logic [PFN_W-1:0]  fill_pfn_i,
    input  logic [PERM_W-1:0] fill_perm_i,
    input  logic              clr_use_i,
    output logic [IDX_W-1:0]  victim_o,
    output logic              victim_dirty_o
);

    typedef struct packed {
        logic              vld;
        logic              used;
        logic              dirty;
        logic [PERM_W-1:0] perm;
        logic [VPN_W-1:0]  tag;
        logic [PFN_W-1:0]  pfn;
    } ent_t;

    typedef struct packed {
        ent_t [N-1:0]    ent;
        logic            hit;
        logic            miss;
        logic            fault;
        logic [PA_W-1:0] paddr;
    } state_t;

    state_t st_d, st_q;

    logic [N-1:0]              vld_vec, used_vec, dirty_vec;
    logic [N-1:0][VPN_W-1:0]   tag_vec;
    logic [N-1:0][PFN_W-1:0]   pfn_vec;
    logic [N-1:0][PERM_W-1:0]  perm_vec;

    for (genvar g = 0; g < N; g++) begin : g_unpack
        assign vld_vec[g]   = st_q.ent[g].vld;
        assign used_vec[g]  = st_q.ent[g].used;
        assign dirty_vec[g] = st_q.ent[g].dirty;
        assign tag_vec[g]   = st_q.ent[g].tag;
        assign pfn_vec[g]   = st_q.ent[g].pfn;
        assign perm_vec[g]  = st_q.ent[g].perm;
    end

    logic [N-1:0]      lk_hv;
    logic              lk_any;
    logic [PFN_W-1:0]  lk_pfn;
    logic [PERM_W-1:0] lk_perm;

    xlat_match #(.N(N), .VPN_W(VPN_W), .PFN_W(PFN_W)) lk_match_i (
        .vpn_i     (lk_vaddr_i[VA_W-1:OFS_W]),
        .vld_i     (vld_vec),
        .tag_i     (tag_vec),
        .pfn_i     (pfn_vec),
        .perm_i    (perm_vec),
        .hit_vec_o (lk_hv),
        .any_o     (lk_any),
        .pfn_o     (lk_pfn),
        .perm_o    (lk_perm)
    );

    xlat_victim #(.N(N)) victim_i (
        .vld_i  (vld_vec),
        .used_i (used_vec),
        .idx_o  (victim_o)
    );

    always_comb begin
        victim_dirty_o = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (victim_o == IDX_W'(i)) victim_dirty_o = dirty_vec[i];
        end
    end

    // Fill target: an entry already holding the tag, else the victim.
    logic [N-1:0] fill_hv, fill_sel;
    for (genvar g = 0; g < N; g++) begin : g_fill_cmp
        assign fill_hv[g] = vld_vec[g] && (tag_vec[g] == fill_vpn_i);
    end

    always_comb begin
        fill_sel = '0;
        if (|fill_hv) begin
            for (int i = N - 1; i >= 0; i--) begin
                if (fill_hv[i]) fill_sel = N'(1) << i;
            end
        end else begin
            fill_sel = N'(1) << victim_o;
        end
    end

    logic lk_ok;
    assign lk_ok = perm_ok(lk_perm, acc_e'(lk_acc_i));

    always_comb begin
        st_d       = st_q;
        st_d.hit   = lk_valid_i && lk_any && lk_ok;
        st_d.fault = lk_valid_i && lk_any && !lk_ok;
        st_d.miss  = lk_valid_i && !lk_any;
        st_d.paddr = st_d.hit ? {lk_pfn, lk_vaddr_i[OFS_W-1:0]} : '0;

        if (clr_use_i) begin
            for (int i = 0; i < N; i++) st_d.ent[i].used = 1'b0;
        end

        for (int i = 0; i < N; i++) begin
            if (st_d.hit && lk_hv[i]) begin
                st_d.ent[i].used = 1'b1;
                if (acc_e'(lk_acc_i) == ACC_STORE) st_d.ent[i].dirty = 1'b1;
            end
        end

        for (int i = 0; i < N; i++) begin
            if (fill_valid_i && fill_sel[i]) begin
                st_d.ent[i].vld   = 1'b1;
                st_d.ent[i].used  = 1'b0;
                st_d.ent[i].dirty = 1'b0;
                st_d.ent[i].perm  = fill_perm_i;
                st_d.ent[i].tag   = fill_vpn_i;
                st_d.ent[i].pfn   = fill_pfn_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign lk_hit_o   = st_q.hit;
    assign lk_miss_o  = st_q.miss;
    assign lk_fault_o = st_q.fault;
    assign lk_paddr_o = st_q.paddr;

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
    parameter int VA_W  = 32,
    parameter int OFS_W = 12,
    parameter int PA_W  = 32
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            lk_valid_i,
    input logic [VA_W-1:0] lk_vaddr_i,
    input logic            lk_hit_o,
    input logic            lk_miss_o,
    input logic            lk_fault_o,
    input logic [PA_W-1:0] lk_paddr_o
);

    AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lk_valid_i |=> $countones({lk_hit_o, lk_miss_o, lk_fault_o}) == 1); // R1

    AST_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lk_valid_i |=> !(lk_hit_o || lk_miss_o || lk_fault_o)); // R1

    AST_OFFSET_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lk_valid_i ##1 lk_hit_o |-> lk_paddr_o[OFS_W-1:0] == $past(lk_vaddr_i[OFS_W-1:0])); // R2

    AST_NO_ADDR_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lk_miss_o |-> lk_paddr_o == '0); // R3

    AST_NO_ADDR_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lk_fault_o |-> lk_paddr_o == '0); // R4

endmodule

bind xlat_cache xlat_cache_chk #(.VA_W(VA_W), .OFS_W(OFS_W), .PA_W(PA_W)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lk_valid_i (lk_valid_i),
    .lk_vaddr_i (lk_vaddr_i),
    .lk_hit_o   (lk_hit_o),
    .lk_miss_o  (lk_miss_o),
    .lk_fault_o (lk_fault_o),
    .lk_paddr_o (lk_paddr_o)
);

// File: tb/xlat_cache_tb_top.sv
module xlat_cache_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [1:0]  lk_acc = '0;
    logic        lk_hit, lk_miss, lk_fault;
    logic [31:0] lk_paddr;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_pfn = '0;
    logic [2:0]  fill_perm = '0;
    logic        clr_use = 1'b0;
    logic [3:0]  victim;
    logic        victim_dirty;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xlat_cache dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .lk_valid_i(lk_valid), .lk_vaddr_i(lk_vaddr), .lk_acc_i(lk_acc),
        .lk_hit_o(lk_hit), .lk_miss_o(lk_miss), .lk_fault_o(lk_fault),
        .lk_paddr_o(lk_paddr),
        .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn), .fill_pfn_i(fill_pfn),
        .fill_perm_i(fill_perm), .clr_use_i(clr_use),
        .victim_o(victim), .victim_dirty_o(victim_dirty)
    );

    typedef struct packed {
        logic [31:0] va;
        logic [1:0]  acc;
        logic [2:0]  res;   // {fault, hit, miss}
        logic [31:0] pa;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{32'h0000_1ABC, 2'b00, 3'b010, 32'hAAAA_AABC},
        '{32'h0000_1123, 2'b01, 3'b010, 32'hAAAA_A123},
        '{32'h1234_5FFF, 2'b00, 3'b010, 32'h0BEE_FFFF},
        '{32'h1234_5000, 2'b01, 3'b100, 32'h0000_0000},
        '{32'hFFFF_F010, 2'b10, 3'b010, 32'h0004_2010},
        '{32'hFFFF_F010, 2'b11, 3'b100, 32'h0000_0000},
        '{32'h0000_2000, 2'b00, 3'b001, 32'h0000_0000},
        '{32'h0000_0ABC, 2'b00, 3'b001, 32'h0000_0000},
        '{32'h0000_1000, 2'b10, 3'b100, 32'h0000_0000}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic lv, input logic [31:0] va, input logic [1:0] acc,
                        input logic fv, input logic [19:0] fvpn, input logic [19:0] fpfn,
                        input logic [2:0] fperm, input logic clr);
        @(negedge clk);
        lk_valid = lv; lk_vaddr = va; lk_acc = acc;
        fill_valid = fv; fill_vpn = fvpn; fill_pfn = fpfn; fill_perm = fperm;
        clr_use = clr;
        @(posedge clk);
        #1;
    endtask

    task automatic do_lk(input logic [31:0] va, input logic [1:0] acc);
        step(1'b1, va, acc, 1'b0, '0, '0, '0, 1'b0);
    endtask

    task automatic do_fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [2:0] perm);
        step(1'b0, '0, '0, 1'b1, vpn, pfn, perm, 1'b0);
    endtask

    task automatic idle();
        step(1'b0, '0, '0, 1'b0, '0, '0, '0, 1'b0);
    endtask

    task automatic chk_res(input string req, input logic [2:0] res, input logic [31:0] pa);
        check({lk_fault, lk_hit, lk_miss} == res, req, 32'({lk_fault, lk_hit, lk_miss}), 32'(res));
        check(lk_paddr == pa, req, lk_paddr, pa);
    endtask

    task automatic chk_vic(input string req, input logic [3:0] v, input logic d);
        check(victim == v, req, 32'(victim), 32'(v));
        check(victim_dirty == d, req, 32'(victim_dirty), 32'(d));
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Reset state (R3, R7)
        idle();
        check({lk_fault, lk_hit, lk_miss} == 3'b000, "R1 idle", 32'({lk_fault, lk_hit, lk_miss}), 0);
        chk_vic("R7 reset victim", 4'd0, 1'b0);
        do_lk(32'h0000_1ABC, 2'b00);
        chk_res("R3 empty miss", 3'b001, 32'h0);

        // Install three translations into entries 0..2 (R8)
        do_fill(20'h00001, 20'hAAAAA, 3'b011);
        chk_vic("R7 next free", 4'd1, 1'b0);
        do_fill(20'h12345, 20'h0BEEF, 3'b001);
        do_fill(20'hFFFFF, 20'h00042, 3'b100);
        chk_vic("R7 next free 3", 4'd3, 1'b0);

        // Table walk: R2 hits, R4 faults, R3 misses
        foreach (VECS[k]) begin
            do_lk(VECS[k].va, VECS[k].acc);
            chk_res(VECS[k].res == 3'b010 ? "R2 table" : (VECS[k].res == 3'b100 ? "R4 table" : "R3 table"),
                    VECS[k].res, VECS[k].pa);
        end
        idle();
        check({lk_fault, lk_hit, lk_miss} == 3'b000, "R1 idle after", 32'({lk_fault, lk_hit, lk_miss}), 0);

        // Fill the rest; entries 0..2 referenced, 3..15 fresh (R7)
        for (int i = 3; i < 16; i++) do_fill(20'h00100 + 20'(i), 20'(i), 3'b111);
        chk_vic("R7 full first unref", 4'd3, 1'b0);
        do_lk(32'h0010_3000, 2'b00);
        chk_vic("R5 hit sets ref", 4'd4, 1'b0);
        do_lk(32'h0010_4000, 2'b01);
        chk_res("R2 store hit", 3'b010, 32'h0000_4000);
        chk_vic("R5 store ref", 4'd5, 1'b0);

        // Clear all references; entry 0 was stored to earlier (R5, R6)
        step(1'b0, '0, '0, 1'b0, '0, '0, '0, 1'b1);
        chk_vic("R5 clear / R6 dirty", 4'd0, 1'b1);

        // Faults leave flags untouched (R10)
        do_lk(32'h0000_1000, 2'b10);
        chk_res("R10 fault", 3'b100, 32'h0);
        chk_vic("R10 no ref on fault", 4'd0, 1'b1);
        do_lk(32'h1234_5000, 2'b01);
        do_lk(32'h0000_1000, 2'b00);
        chk_vic("R10 no dirty on fault", 4'd1, 1'b0);

        // Clear and hit together: hit entry keeps its reference (R5)
        step(1'b1, 32'h1234_5000, 2'b00, 1'b0, '0, '0, '0, 1'b1);
        chk_vic("R5 clear vs hit", 4'd0, 1'b1);
        do_lk(32'h0000_1000, 2'b00);
        chk_vic("R5 hit survived clear", 4'd2, 1'b0);
        do_lk(32'hFFFF_F000, 2'b10);
        do_lk(32'h0010_3000, 2'b00);
        chk_vic("R6 dirty kept", 4'd4, 1'b1);

        // Refill of an existing tag overwrites in place (R8)
        do_fill(20'h00001, 20'h55555, 3'b111);
        chk_vic("R8 overwrite clears flags", 4'd0, 1'b0);
        do_lk(32'h0000_1777, 2'b10);
        chk_res("R8 new mapping", 3'b010, 32'h5555_5777);
        chk_vic("R8 single copy", 4'd4, 1'b1);

        // Fill and lookup on the same entry in one cycle (R9)
        step(1'b1, 32'h0010_4ABC, 2'b01, 1'b1, 20'h00200, 20'h77777, 3'b001, 1'b0);
        chk_res("R9 old contents", 3'b010, 32'h0000_4ABC);
        chk_vic("R9 fill wins", 4'd4, 1'b0);
        do_lk(32'h0010_4ABC, 2'b00);
        chk_res("R9 old tag gone", 3'b001, 32'h0);
        do_lk(32'h0020_0123, 2'b00);
        chk_res("R9 new tag", 3'b010, 32'h7777_7123);

        // Reset mid-run empties the array (R3, R7)
        @(negedge clk);
        rst_n = 1'b0;
        lk_valid = 1'b0;
        @(posedge clk);
        #1;
        chk_vic("R7 after reset", 4'd0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        do_lk(32'h0020_0123, 2'b00);
        chk_res("R3 miss after reset", 3'b001, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule